// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an active-low reset push-button stays pressed, so that system software can tell a short tap from a long press and start a factory-default procedure. The button input is asynchronous. It passes through a flop synchroniser, and while the synchronised level is low a saturating counter advances once per tick of the reference clock. The nominal clock is 25 MHz, so one count is 40 ns. With the default 29-bit width the counter spans about 21.4 seconds before it stops at its ceiling.

When the button is released, the count is held so that software can read it at any later time. Software clears the count by writing a word with bit 31 set. If the count has not been cleared, a later press adds to the value already held. A programmable limit in whole seconds drives a sticky long-press flag. The limit is converted to ticks through the ticks-per-second parameter. The flag drops only when the count is cleared.

Top module: `rsthold_meter`

## Requirements
- R1: While the synchronised button level is low, the count rises by exactly one per clock edge. While it is high, the count keeps its value, so the value that remains after release equals the number of cycles the button was held.
- R2: The button input passes through SYNC_STAGES flops (default 2). After the input falls, the first increment appears at the third rising clock edge.
- R3: The count saturates at 2^CNT_W-1 and stays there while the button is still held. It never wraps.
- R4: A write (wr_en high) with wr_data bit 31 set clears the count and the long-press flag at the next edge. A write with bit 31 clear changes nothing.
- R5: When a clear and an increment fall in the same cycle, the clear wins and the count is 0 after that edge.
- R6: rd_data carries the count in bits [CNT_W-1:0], and every bit above is 0.
- R7: A new press that comes without an intervening clear continues from the held value instead of starting from zero.
- R8: long_press becomes 1 one edge after the count is at least limit_sec × TICKS_PER_SEC. It stays 1 until a clear. With limit_sec = 0 it never sets.
- R9: While rst_n is low, the count is 0 and long_press is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominally 25 MHz) |
| rst_n | input | 1 | Block reset, active low |
| btn_n | input | 1 | Asynchronous reset-button level, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bit 31 requests a clear |
| rd_data | output | 32 | Count in the low CNT_W bits, zeros above |
| limit_sec | input | LIM_W | Long-press limit in seconds; 0 disables the flag |
| long_press | output | 1 | Sticky flag: the limit has been reached |

## Verification
The case hardest to reach from the ports is a clear that lands in the same cycle as an increment. To get there, the bench holds the button low until counting is under way and then issues the clearing write in the middle of the hold. It checks that the count reads zero right after that edge and one an edge later. Saturation is reached in a short run by setting the counter width and ticks per second small in the bench. The limit comparison is tested exactly at the threshold, one tick below it, and across two presses that accumulate.

// File: rtl/rsthold_pkg.sv
package rsthold_pkg;
   localparam int REG_W   = 32;
   localparam int CLR_BIT = 31;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rsthold_sync.sv
module rsthold_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rsthold_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= IDLE_VAL;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= IDLE_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rsthold_count.sv
module rsthold_count #(
   parameter int W = 29
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic at_max;
   assign at_max = (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clr)             cnt <= '0;
      else if (inc && !at_max)  cnt <= cnt + 1'b1;
   end

   // R3
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_max && !clr) |=> (cnt == CNT_MAX));
   // R5
   clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(cnt));
   // R1
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && !at_max) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rsthold_limit.sv
module rsthold_limit
   import rsthold_pkg::*;
#(
   parameter int W     = 29,
   parameter int LIM_W = 8,
   parameter int TICKS = 25_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     cnt,
   input  logic [LIM_W-1:0] limit,
   input  logic             clr,
   output logic             flag
);
   localparam int TKW = $clog2(TICKS + 1);
   localparam int TW  = LIM_W + TKW;
   localparam int CW  = max_i(TW, W);

   if (TICKS < 1) begin : g_bad_ticks
      $error("rsthold_limit: TICKS must be positive");
   end

   logic [TW-1:0] thresh;
   logic          hit;

   assign thresh = TW'(limit) * TW'(TICKS);
   assign hit    = (limit != '0) && (CW'(cnt) >= CW'(thresh));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (clr)  flag <= 1'b0;
      else if (hit)  flag <= 1'b1;
   end

   // R4
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag);
   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   // R8
   flag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0 && !flag) |=> !flag);
endmodule

// File: rtl/rsthold_meter.sv
module rsthold_meter
   import rsthold_pkg::*;
#(
   parameter int CNT_W         = 29,
   parameter int TICKS_PER_SEC = 25_000_000,
   parameter int LIM_W         = 8,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             btn_n,
   input  logic             wr_en,
   input  logic [31:0]      wr_data,
   output logic [31:0]      rd_data,
   input  logic [LIM_W-1:0] limit_sec,
   output logic             long_press
);
   if (CNT_W < 1 || CNT_W > CLR_BIT) begin : g_bad_width
      $error("rsthold_meter: CNT_W must lie in 1..31");
   end

   logic             btn_sync_n;
   logic             clr;
   logic [CNT_W-1:0] cnt;
   logic             unused_wr;

   assign clr       = wr_en & wr_data[CLR_BIT];
   assign unused_wr = ^wr_data[CLR_BIT-1:0];

   rsthold_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(btn_n), .sync_out(btn_sync_n));

   rsthold_count #(.W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .inc(!btn_sync_n), .clr(clr), .cnt(cnt));

   rsthold_limit #(.W(CNT_W), .LIM_W(LIM_W), .TICKS(TICKS_PER_SEC)) u_limit (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .limit(limit_sec),
      .clr(clr), .flag(long_press));

   assign rd_data = {{(REG_W-CNT_W){1'b0}}, cnt};

   // R4
   nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && btn_sync_n) |=> $stable(rd_data));
endmodule

// File: tb/rsthold_meter_test.sv
module rsthold_meter_test;
   localparam int CW = 8;
   localparam int TK = 10;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          btn_n = 1'b1;
   logic          wr_en = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic [LW-1:0] limit_sec = '0;
   logic          long_press;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   rsthold_meter #(.CNT_W(CW), .TICKS_PER_SEC(TK), .LIM_W(LW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .limit_sec(limit_sec), .long_press(long_press));

   // columns: clear first, hold cycles, limit, expected count, expected flag
   localparam int NV = 8;
   localparam int VEC [0:NV-1][0:4] = '{
      '{1,  5, 2,  5, 0},   // R1
      '{0,  7, 2, 12, 0},   // R7 accumulate
      '{0,  9, 2, 21, 1},   // R8 crossing over two presses
      '{1, 20, 2, 20, 1},   // R8 exactly at limit
      '{1, 19, 2, 19, 0},   // R8 one below
      '{1, 40, 0, 40, 0},   // R8 limit zero
      '{1,  0, 3,  0, 0},   // R4 clear only
      '{1, 30, 3, 30, 1}    // R8
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_clear();
      wr_en = 1'b1; wr_data = 32'h8000_0000;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic press(input int n);
      if (n > 0) begin
         btn_n = 1'b0;
         repeat (n) @(negedge clk);
         btn_n = 1'b1;
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", rd_data, 32'h0);
      chk("R9", {31'h0, long_press}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         limit_sec = LW'(VEC[v][2]);
         if (VEC[v][0] != 0) do_clear();
         press(VEC[v][1]);
         chk("R1/R6/R7 count", rd_data, 32'(VEC[v][3]));
         chk("R8 flag", {31'h0, long_press}, 32'(VEC[v][4]));
      end

      // R2 latency, then R5 clear beats increment
      limit_sec = '0;
      do_clear();
      btn_n = 1'b0;
      @(negedge clk); chk("R2 edge1", rd_data, 32'd0);
      @(negedge clk); chk("R2 edge2", rd_data, 32'd0);
      @(negedge clk); chk("R2 edge3", rd_data, 32'd1);
      repeat (4) @(negedge clk);
      chk("R1 while held", rd_data, 32'd5);
      wr_en = 1'b1; wr_data = 32'h8000_0000;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      chk("R5 clear wins", rd_data, 32'd0);
      @(negedge clk);
      chk("R5 resumes", rd_data, 32'd1);
      btn_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 held after release", rd_data, 32'd3);

      // R4 write without bit 31 ignored
      wr_en = 1'b1; wr_data = 32'h7FFF_FFFF;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      @(negedge clk);
      chk("R4 no clear", rd_data, 32'd3);

      // R3 saturation and R6 upper bits
      limit_sec = LW'(15);
      do_clear();
      press(300);
      chk("R3 saturate", rd_data, 32'd255);
      chk("R8 flag at sat", {31'h0, long_press}, 32'd1);
      press(10);
      chk("R3 stays", rd_data, 32'd255);
      do_clear();
      chk("R4 clear count", rd_data, 32'd0);
      chk("R4 clear flag", {31'h0, long_press}, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule